// File: doc/BRIEF.md
# Asymmetric Dual-Port Parity RAM

A synchronous dual-port memory of 18 Kbit: 16 Kbit of data plus 2 Kbit of parity. Each port has its own clock, enable, write enable and synchronous output reset. A parameter sets each port's aspect ratio on its own, so one port can write wide words while the other reads narrow slices of the same array. The block therefore converts bus widths as part of storage.

The array is organised as 512 rows. Each row holds a 32-bit data word and 4 parity bits, and parity bit k guards data byte k. A port in a byte-plus-parity mode (x9, x18, x36) reaches the data bits and the parity bits of its lanes. A port in a plain mode (x1, x2, x4) reaches only the data bits. Memory contents start at zero.

Top module: `asym_dp_ram`

## Requirements
- R1: Each port's data width parameter is 1, 2, 4, 8, 16 or 32. The port then has 16384/width addresses, an address bus of log2(16384/width) bits, and a parity width of width/8 in the byte modes (1 bit in plain modes). The two widths are chosen independently.
- R2: A read with enable high and write enable low presents the addressed word on the data and parity outputs after the next clock edge of that port.
- R3: With enable low, a clock edge changes neither the output registers nor the memory, whatever write enable, address and data are.
- R4: A write (enable and write enable high, reset low) stores the word and shows the written data on the port's outputs after the same edge.
- R5: Reset with enable high forces the data and parity outputs to zero at the clock edge and leaves memory contents unchanged.
- R6: Mapping is little-endian. Narrow address a reaches row a / (32/w), lane a mod (32/w), which is data bits [lane*w +: w] of that row.
- R7: In byte modes, lane l of a w-bit port owns parity bits [l*w/8 +: w/8] of the row. Parity bit k therefore follows data byte k across ports of different widths.
- R8: In plain modes the parity output is always zero and the parity input is ignored. A plain-mode write changes only data bits, never stored parity.
- R9: rst_ni low clears both output registers of both ports asynchronously and does not touch memory.
- R10: Writes from the two ports on the same cycle to disjoint bits both take effect, including bits in the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| clk_a_i | input | 1 | Port A clock |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| ssr_a_i | input | 1 | Port A synchronous output reset |
| addr_a_i | input | log2(16384/DW_A) | Port A address |
| din_a_i | input | DW_A | Port A write data |
| dinp_a_i | input | max(DW_A/8,1) | Port A write parity |
| dout_a_o | output | DW_A | Port A read data |
| doutp_a_o | output | max(DW_A/8,1) | Port A read parity |
| clk_b_i | input | 1 | Port B clock |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| ssr_b_i | input | 1 | Port B synchronous output reset |
| addr_b_i | input | log2(16384/DW_B) | Port B address |
| din_b_i | input | DW_B | Port B write data |
| dinp_b_i | input | max(DW_B/8,1) | Port B write parity |
| dout_b_o | output | DW_B | Port B read data |
| doutp_b_o | output | max(DW_B/8,1) | Port B read parity |

## Verification
The bench pairs a 32-bit port with a 4-bit port and an 8-bit port with a 16-bit port. It writes a nibble into a wide word and reads it back wide. A swapped lane order shows up as the wrong nibble, and a plain write that leaks into parity shows up as changed parity bits. It writes bytes and half-words into the same row on one edge and reads them back across widths. A lost write, or parity bits tied to the wrong byte, returns stale or misplaced parity. It drives the write enable while the port enable is low, and asserts reset between writes and reads. A design that ignores the enable would overwrite the row. A design whose reset cleared memory would lose the stored word after the outputs return to zero.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;
  localparam int DATA_W = 32;
  localparam int PAR_W  = DATA_W / 8;
  localparam int ROW_W  = DATA_W + PAR_W;
  localparam int ROWS   = 512;
  localparam int ROW_AW = $clog2(ROWS);

  typedef logic [ROW_W-1:0] row_t;

  function automatic int lane_bits(int dw);
    return $clog2(DATA_W / dw);
  endfunction

  function automatic int par_bits(int dw);
    return (dw >= 8) ? dw / 8 : 1;
  endfunction

  function automatic bit has_par(int dw);
    return dw >= 8;
  endfunction
endpackage

// File: rtl/asym_ram_lane_map.sv
module asym_ram_lane_map import asym_ram_pkg::*; #(
  parameter  int DW   = 8,
  localparam int LB   = lane_bits(DW),
  localparam int AW   = ROW_AW + LB,
  localparam int PW   = par_bits(DW)
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     din_i,
  input  logic [PW-1:0]     dinp_i,
  input  row_t              rd_row_i,
  output logic [ROW_AW-1:0] row_o,
  output row_t              mask_o,
  output row_t              wbits_o,
  output logic [DW-1:0]     rdat_o,
  output logic [PW-1:0]     rpar_o
);
  localparam int  LANES = 1 << LB;
  localparam int  LB_S  = (LB > 0) ? LB : 1;
  localparam bit  HP    = has_par(DW);

  logic [LB_S-1:0] lane;

  generate
    if (LB == 0) begin : g_full
      assign row_o = addr_i;
      assign lane  = '0;
    end else begin : g_lane
      assign row_o = addr_i[AW-1:LB];
      assign lane  = addr_i[LB-1:0];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mask_o[i]  = wr_i && ((i / DW) == int'(lane));
      wbits_o[i] = din_i[i % DW];
    end
    for (int j = 0; j < PAR_W; j++) begin
      mask_o[DATA_W+j]  = HP && wr_i && ((j / PW) == int'(lane));
      wbits_o[DATA_W+j] = dinp_i[j % PW];
    end
  end

  always_comb begin
    rdat_o = '0;
    for (int l = 0; l < LANES; l++)
      if (int'(lane) == l) rdat_o = rd_row_i[l*DW +: DW];
  end

  generate
    if (HP) begin : g_par
      always_comb begin
        rpar_o = '0;
        for (int l = 0; l < LANES; l++)
          if (int'(lane) == l) rpar_o = rd_row_i[DATA_W + l*PW +: PW];
      end
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^rd_row_i[ROW_W-1:DATA_W];
      assign rpar_o     = '0;
    end
  endgenerate
endmodule

// File: rtl/asym_ram_bank.sv
module asym_ram_bank import asym_ram_pkg::*; (
  input  logic              clk_i,
  input  logic [ROW_AW-1:0] row_w_i,
  input  row_t              mask_i,
  input  row_t              bits_i,
  input  logic [ROW_AW-1:0] row_a_i,
  input  logic [ROW_AW-1:0] row_b_i,
  output row_t              rd_a_o,
  output row_t              rd_b_o
);
  row_t mem [ROWS] = '{default: '0};

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < ROW_W; i++)
      if (mask_i[i]) mem[row_w_i][i] <= bits_i[i];
  end

  assign rd_a_o = mem[row_a_i];
  assign rd_b_o = mem[row_b_i];
endmodule

// File: rtl/asym_ram_out_reg.sv
module asym_ram_out_reg #(
  parameter int DW = 8,
  parameter int PW = 1,
  parameter bit HP = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic          ssr_i,
  input  logic [DW-1:0] din_i,
  input  logic [PW-1:0] dinp_i,
  input  logic [DW-1:0] rdat_i,
  input  logic [PW-1:0] rpar_i,
  output logic [DW-1:0] dout_o,
  output logic [PW-1:0] doutp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o  <= '0;
      doutp_o <= '0;
    end else if (en_i) begin
      if (ssr_i) begin
        dout_o  <= '0;
        doutp_o <= '0;
      end else if (we_i) begin
        dout_o  <= din_i;
        doutp_o <= HP ? dinp_i : '0;
      end else begin
        dout_o  <= rdat_i;
        doutp_o <= rpar_i;
      end
    end
  end
endmodule

// File: rtl/asym_dp_ram.sv
module asym_dp_ram import asym_ram_pkg::*; #(
  parameter  int DW_A = 32,
  parameter  int DW_B = 4,
  localparam int AW_A = ROW_AW + lane_bits(DW_A),
  localparam int AW_B = ROW_AW + lane_bits(DW_B),
  localparam int PW_A = par_bits(DW_A),
  localparam int PW_B = par_bits(DW_B)
) (
  input  logic            rst_ni,
  input  logic            clk_a_i,
  input  logic            en_a_i,
  input  logic            we_a_i,
  input  logic            ssr_a_i,
  input  logic [AW_A-1:0] addr_a_i,
  input  logic [DW_A-1:0] din_a_i,
  input  logic [PW_A-1:0] dinp_a_i,
  output logic [DW_A-1:0] dout_a_o,
  output logic [PW_A-1:0] doutp_a_o,
  input  logic            clk_b_i,
  input  logic            en_b_i,
  input  logic            we_b_i,
  input  logic            ssr_b_i,
  input  logic [AW_B-1:0] addr_b_i,
  input  logic [DW_B-1:0] din_b_i,
  input  logic [PW_B-1:0] dinp_b_i,
  output logic [DW_B-1:0] dout_b_o,
  output logic [PW_B-1:0] doutp_b_o
);
  logic [ROW_AW-1:0] row_a, row_b;
  row_t mask_a, mask_b, wbits_a, wbits_b;
  row_t rd_aa, rd_ab, rd_ba, rd_bb;
  row_t val_a, val_b;
  logic [DW_A-1:0] rdat_a;
  logic [DW_B-1:0] rdat_b;
  logic [PW_A-1:0] rpar_a;
  logic [PW_B-1:0] rpar_b;

  // stored row = bank_a ^ bank_b; each bank has one writer
  assign val_a = rd_aa ^ rd_ba;
  assign val_b = rd_ab ^ rd_bb;

  asym_ram_lane_map #(.DW(DW_A)) map_a_i (
    .addr_i(addr_a_i), .wr_i(en_a_i && we_a_i), .din_i(din_a_i), .dinp_i(dinp_a_i),
    .rd_row_i(val_a), .row_o(row_a), .mask_o(mask_a), .wbits_o(wbits_a),
    .rdat_o(rdat_a), .rpar_o(rpar_a)
  );

  asym_ram_lane_map #(.DW(DW_B)) map_b_i (
    .addr_i(addr_b_i), .wr_i(en_b_i && we_b_i), .din_i(din_b_i), .dinp_i(dinp_b_i),
    .rd_row_i(val_b), .row_o(row_b), .mask_o(mask_b), .wbits_o(wbits_b),
    .rdat_o(rdat_b), .rpar_o(rpar_b)
  );

  asym_ram_bank bank_a_i (
    .clk_i(clk_a_i), .row_w_i(row_a), .mask_i(mask_a), .bits_i(wbits_a ^ rd_ba),
    .row_a_i(row_a), .row_b_i(row_b), .rd_a_o(rd_aa), .rd_b_o(rd_ab)
  );

  asym_ram_bank bank_b_i (
    .clk_i(clk_b_i), .row_w_i(row_b), .mask_i(mask_b), .bits_i(wbits_b ^ rd_ab),
    .row_a_i(row_a), .row_b_i(row_b), .rd_a_o(rd_ba), .rd_b_o(rd_bb)
  );

  asym_ram_out_reg #(.DW(DW_A), .PW(PW_A), .HP(has_par(DW_A))) out_a_i (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .en_i(en_a_i), .we_i(we_a_i), .ssr_i(ssr_a_i),
    .din_i(din_a_i), .dinp_i(dinp_a_i), .rdat_i(rdat_a), .rpar_i(rpar_a),
    .dout_o(dout_a_o), .doutp_o(doutp_a_o)
  );

  asym_ram_out_reg #(.DW(DW_B), .PW(PW_B), .HP(has_par(DW_B))) out_b_i (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .en_i(en_b_i), .we_i(we_b_i), .ssr_i(ssr_b_i),
    .din_i(din_b_i), .dinp_i(dinp_b_i), .rdat_i(rdat_b), .rpar_i(rpar_b),
    .dout_o(dout_b_o), .doutp_o(doutp_b_o)
  );
endmodule

// File: rtl/asym_ram_chk.sv
module asym_ram_chk import asym_ram_pkg::*; #(
  parameter  int DW_A = 32,
  parameter  int DW_B = 4,
  localparam int PW_A = par_bits(DW_A),
  localparam int PW_B = par_bits(DW_B)
) (
  input logic            rst_ni,
  input logic            clk_a_i,
  input logic            en_a_i,
  input logic            we_a_i,
  input logic            ssr_a_i,
  input logic [DW_A-1:0] din_a_i,
  input logic [PW_A-1:0] dinp_a_i,
  input logic [DW_A-1:0] dout_a_o,
  input logic [PW_A-1:0] doutp_a_o,
  input logic            clk_b_i,
  input logic            en_b_i,
  input logic            we_b_i,
  input logic            ssr_b_i,
  input logic [DW_B-1:0] din_b_i,
  input logic [PW_B-1:0] dinp_b_i,
  input logic [DW_B-1:0] dout_b_o,
  input logic [PW_B-1:0] doutp_b_o
);
  localparam bit HP_A = has_par(DW_A);
  localparam bit HP_B = has_par(DW_B);

  // R3
  hold_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !en_a_i |=> $stable(dout_a_o) && $stable(doutp_a_o));
  // R3
  hold_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !en_b_i |=> $stable(dout_b_o) && $stable(doutp_b_o));
  // R4
  wfirst_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    en_a_i && we_a_i && !ssr_a_i |=> dout_a_o == $past(din_a_i));
  // R4
  wfirst_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    en_b_i && we_b_i && !ssr_b_i |=> dout_b_o == $past(din_b_i));
  // R5
  ssr_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    en_a_i && ssr_a_i |=> dout_a_o == '0 && doutp_a_o == '0);
  // R5
  ssr_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    en_b_i && ssr_b_i |=> dout_b_o == '0 && doutp_b_o == '0);
  // R7 R8
  wpar_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    en_a_i && we_a_i && !ssr_a_i |=> doutp_a_o == (HP_A ? $past(dinp_a_i) : '0));
  // R7 R8
  wpar_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    en_b_i && we_b_i && !ssr_b_i |=> doutp_b_o == (HP_B ? $past(dinp_b_i) : '0));
endmodule

bind asym_dp_ram asym_ram_chk #(.DW_A(DW_A), .DW_B(DW_B)) chk_i (
  .rst_ni(rst_ni),
  .clk_a_i(clk_a_i), .en_a_i(en_a_i), .we_a_i(we_a_i), .ssr_a_i(ssr_a_i),
  .din_a_i(din_a_i), .dinp_a_i(dinp_a_i), .dout_a_o(dout_a_o), .doutp_a_o(doutp_a_o),
  .clk_b_i(clk_b_i), .en_b_i(en_b_i), .we_b_i(we_b_i), .ssr_b_i(ssr_b_i),
  .din_b_i(din_b_i), .dinp_b_i(dinp_b_i), .dout_b_o(dout_b_o), .doutp_b_o(doutp_b_o)
);

// File: tb/asym_dp_ram_tb_top.sv
module asym_dp_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  typedef struct {
    int          port;
    logic [31:0] d;
    logic [3:0]  p;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  int checks = 0;
  int errors = 0;

  logic        en_s   [4];
  logic        we_s   [4];
  logic        ssr_s  [4];
  logic [11:0] addr_s [4];
  logic [31:0] din_s  [4];
  logic [3:0]  dinp_s [4];
  logic [31:0] dout_s [4];
  logic [3:0]  doutp_s[4];

  logic [31:0] o0; logic [3:0] op0;
  logic [3:0]  o1; logic       op1;
  logic [7:0]  o2; logic       op2;
  logic [15:0] o3; logic [1:0] op3;

  item_t sb_q[$];
  item_t pend[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // port 0: x36, port 1: x4
  asym_dp_ram #(.DW_A(32), .DW_B(4)) dut_i (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .en_a_i(en_s[0]), .we_a_i(we_s[0]), .ssr_a_i(ssr_s[0]),
    .addr_a_i(addr_s[0][8:0]), .din_a_i(din_s[0]), .dinp_a_i(dinp_s[0]),
    .dout_a_o(o0), .doutp_a_o(op0),
    .clk_b_i(clk), .en_b_i(en_s[1]), .we_b_i(we_s[1]), .ssr_b_i(ssr_s[1]),
    .addr_b_i(addr_s[1][11:0]), .din_b_i(din_s[1][3:0]), .dinp_b_i(dinp_s[1][0]),
    .dout_b_o(o1), .doutp_b_o(op1)
  );

  // port 2: x9, port 3: x18
  asym_dp_ram #(.DW_A(8), .DW_B(16)) dut_w_i (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .en_a_i(en_s[2]), .we_a_i(we_s[2]), .ssr_a_i(ssr_s[2]),
    .addr_a_i(addr_s[2][10:0]), .din_a_i(din_s[2][7:0]), .dinp_a_i(dinp_s[2][0]),
    .dout_a_o(o2), .doutp_a_o(op2),
    .clk_b_i(clk), .en_b_i(en_s[3]), .we_b_i(we_s[3]), .ssr_b_i(ssr_s[3]),
    .addr_b_i(addr_s[3][9:0]), .din_b_i(din_s[3][15:0]), .dinp_b_i(dinp_s[3][1:0]),
    .dout_b_o(o3), .doutp_b_o(op3)
  );

  assign dout_s[0] = o0;          assign doutp_s[0] = op0;
  assign dout_s[1] = {28'd0, o1}; assign doutp_s[1] = {3'd0, op1};
  assign dout_s[2] = {24'd0, o2}; assign doutp_s[2] = {3'd0, op2};
  assign dout_s[3] = {16'd0, o3}; assign doutp_s[3] = {2'd0, op3};

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations after each edge
  always @(posedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check($sformatf("%s port%0d", it.tag, it.port),
            {doutp_s[it.port], dout_s[it.port]}, {it.p, it.d});
    end
  end

  task automatic expect_out(int p, logic [31:0] d, logic [3:0] pr, string tag);
    item_t it;
    it.port = p; it.d = d; it.p = pr; it.tag = tag;
    pend.push_back(it);
  endtask

  task automatic rd(int p, logic [11:0] a, logic [31:0] d, logic [3:0] pr, string tag);
    en_s[p] = 1'b1; we_s[p] = 1'b0; ssr_s[p] = 1'b0; addr_s[p] = a;
    expect_out(p, d, pr, tag);
  endtask

  task automatic wr(int p, logic [11:0] a, logic [31:0] d, logic [3:0] dp,
                    logic [3:0] exp_p, string tag);
    en_s[p] = 1'b1; we_s[p] = 1'b1; ssr_s[p] = 1'b0; addr_s[p] = a;
    din_s[p] = d; dinp_s[p] = dp;
    expect_out(p, d, exp_p, tag);
  endtask

  task automatic tick();
    @(posedge clk);
    while (pend.size() > 0) sb_q.push_back(pend.pop_front());
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      en_s[p] = 1'b0; we_s[p] = 1'b0; ssr_s[p] = 1'b0;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      en_s[p] = 1'b0; we_s[p] = 1'b0; ssr_s[p] = 1'b0;
      addr_s[p] = '0; din_s[p] = '0; dinp_s[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int p = 0; p < 4; p++)
      check($sformatf("R9 reset port%0d", p), {doutp_s[p], dout_s[p]}, 36'd0);
    // R1 address widths per mode
    check("R1 addr width x36", 36'($bits(dut_i.addr_a_i)), 36'd9);
    check("R1 addr width x4", 36'($bits(dut_i.addr_b_i)), 36'd12);
    check("R1 addr width x9", 36'($bits(dut_w_i.addr_a_i)), 36'd11);
    check("R1 addr width x18", 36'($bits(dut_w_i.addr_b_i)), 36'd10);
    rst_ni = 1'b1;
    @(negedge clk);

    wr(0, 5, 32'hA1B2C3D4, 4'hA, 4'hA, "R4 write-first x36"); tick();
    rd(0, 5, 32'hA1B2C3D4, 4'hA, "R2 read x36");
    rd(1, 40, 32'h4, 4'h0, "R6 lane0 x4"); tick();
    rd(1, 47, 32'hA, 4'h0, "R6 lane7 x4"); tick();
    wr(1, 41, 32'h9, 4'h1, 4'h0, "R8 narrow write-first"); tick();
    rd(0, 5, 32'hA1B2C394, 4'hA, "R8 R6 narrow lane keeps parity"); tick();
    // R3: enable low with write enable set
    we_s[0] = 1'b1; addr_s[0] = 5; din_s[0] = 32'hFFFFFFFF; dinp_s[0] = 4'hF;
    expect_out(0, 32'hA1B2C394, 4'hA, "R3 hold output"); tick();
    rd(0, 5, 32'hA1B2C394, 4'hA, "R3 no write"); tick();
    en_s[0] = 1'b1; ssr_s[0] = 1'b1; addr_s[0] = 5;
    expect_out(0, 32'h0, 4'h0, "R5 ssr zeroes"); tick();
    rd(0, 5, 32'hA1B2C394, 4'hA, "R5 memory kept"); tick();
    wr(0, 511, 32'h76543210, 4'h5, 4'h5, "R1 top row x36");
    wr(1, 8, 32'h3, 4'h0, 4'h0, "R10 same-cycle narrow write"); tick();
    rd(1, 4095, 32'h7, 4'h0, "R1 top addr x4");
    rd(0, 1, 32'h00000003, 4'h0, "R10 narrow write landed"); tick();
    rd(1, 4088, 32'h0, 4'h0, "R1 R6 top row lane0"); tick();

    wr(3, 6, 32'h1234, 4'h2, 4'h2, "R4 write-first x18"); tick();
    wr(2, 12, 32'h5A, 4'h1, 4'h1, "R10 byte write");
    wr(3, 7, 32'hBEEF, 4'h1, 4'h1, "R10 half write"); tick();
    rd(3, 6, 32'h125A, 4'h3, "R7 R10 merged half");
    rd(2, 13, 32'h12, 4'h1, "R7 byte1 parity"); tick();
    rd(2, 15, 32'hBE, 4'h0, "R7 byte3 parity");
    rd(3, 7, 32'hBEEF, 4'h1, "R10 upper half"); tick();
    rd(2, 14, 32'hEF, 4'h1, "R7 byte2 parity"); tick();
    wr(3, 1023, 32'hCAFE, 4'h3, 4'h3, "R1 top addr x18"); tick();
    rd(2, 2047, 32'hCA, 4'h1, "R1 R7 top addr x9"); tick();
    rd(2, 2046, 32'hFE, 4'h1, "R1 R7 x9 byte2"); tick();

    // R9 async reset mid-run
    rst_ni = 1'b0;
    #1;
    for (int p = 0; p < 4; p++)
      check($sformatf("R9 async clear port%0d", p), {doutp_s[p], dout_s[p]}, 36'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(0, 5, 32'hA1B2C394, 4'hA, "R9 memory survives reset");
    rd(3, 7, 32'hBEEF, 4'h1, "R9 memory survives reset"); tick();
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule